// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a clocked host and an external asynchronous static RAM of 262144 bytes. The host hands over one byte-wide read or write at a time through a valid/ready handshake. The block then drives the 18-bit address, the active-low select, output-enable and write-enable strobes, and the outbound half of the bidirectional data bus together with its tri-state enable. When the access is complete, it returns a one-cycle done pulse and, for reads, the byte it captured.

All strobes are registered, so they change only at clock edges. Every minimum interval the memory needs is a nanosecond figure. The block divides each figure by a clock-period parameter, rounds up to whole cycles with a floor of one cycle, and uses the result to load a single down-counter. A speed-grade parameter chooses between the fast and the slow set of figures. After every read, a fixed turnaround wait keeps the block from driving the bus while the memory may still be releasing it.

Top module: `async_sram_ctrl`

## Requirements
- R1: While reset is held, and right after it is released, sel_n, oe_n and we_n are 1, dq_oe is 0, req_ready is 1 and rsp_done is 0.
- R2: A request is taken only at a clock edge where req_valid and req_ready are both 1. From the next cycle sel_n is 0 and req_ready is 0. A req_valid pulse while req_ready is 0 has no effect on the memory.
- R3: A read asserts sel_n at the accept edge and oe_n one edge later. The byte on sram_dq_in is captured at accept edge + Lr, where Lr = max(ceil(Trc/T) - 2, ceil(35/T) - 1, 1) + 2. T is the clock period and Trc is 55 ns (fast) or 70 ns (slow). With the defaults, Lr is 6 (fast) or 7 (slow).
- R4: rsp_done is high for exactly one cycle per access. It rises at the capture edge for a read and at the release edge for a write. rsp_rdata shows the last byte read and keeps it through later writes.
- R5: After oe_n returns high, dq_oe and req_ready stay 0 for ceil(Thz/T) cycles, where Thz is 25 ns (fast) or 30 ns (slow). This is 3 cycles with the defaults. The memory can therefore release the bus before the block drives it.
- R6: A write drives sel_n low and dq_oe high at the accept edge, pulls we_n low one edge later and holds it low for Nw = max(ceil(Twp/T), ceil(Taw/T) - 1, ceil(40/T) - 1, 1) cycles. Twp and Taw are 45 ns each for the fast grade, and 55 ns and 60 ns for the slow grade. One cycle after we_n rises, sel_n rises and dq_oe drops. rsp_done follows at accept edge + Nw + 2, which is 7 (fast) or 8 (slow).
- R7: The address and write byte are latched at the accept edge and stay unchanged while sel_n is 0. A byte written to an address is the byte later read from it.
- R8: oe_n is never 0 while we_n is 0 or while dq_oe is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Byte address |
| req_wdata | input | 8 | Byte to write |
| req_ready | output | 1 | Block idle, request may be taken |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Last captured read byte |
| sram_addr | output | 18 | Memory address bus |
| sram_dq_out | output | 8 | Byte driven toward memory |
| sram_dq_oe | output | 1 | Tri-state enable for sram_dq_out |
| sram_dq_in | input | 8 | Byte seen on the memory data pins |
| sram_sel_n | output | 1 | Active-low chip select |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_we_n | output | 1 | Active-low write enable |

## Verification
Two functions can fall on the same edge: the end of a read, where the memory may still be driving the bus after oe_n rises, and the start of a write, where the block begins to drive the same bus. The bench provokes this overlap by issuing a write the moment req_ready returns after a read, both in directed pairs and throughout a random mix. It judges the result with a cycle-level memory model that keeps driving for the float window after oe_n rises, and it flags any cycle in which dq_oe is also high. The same model returns the complement of the stored byte until the access time has elapsed, so a capture that comes too early shows up as a scoreboard mismatch.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_SETUP, ST_RD_WAIT, ST_RD_CAPTURE,
    ST_TURNAROUND, ST_WR_SETUP, ST_WR_PULSE, ST_WR_END
  } sramc_state_e;

  // nanoseconds to whole clock cycles, rounded up, at least one
  function automatic int ns2cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // cycles spent in the read wait state; capture lands two edges later
  function automatic int rd_wait_len(input int c_rc, input int c_oe);
    return imax(imax(c_rc - 2, c_oe - 1), 1);
  endfunction

  // cycles of write-enable low; address/data lead by one setup cycle
  function automatic int wr_pulse_len(input int c_wp, input int c_aw, input int c_dw);
    return imax(imax(c_wp, c_aw - 1), imax(c_dw - 1, 1));
  endfunction

endpackage

// File: rtl/sramc_timer.sv
module sramc_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          zero
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/sramc_dpath.sv
module sramc_dpath #(
  parameter int AW = 18,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          cap_en,
  input  logic [DW-1:0] dq_in,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic [DW-1:0] rdata_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (cap_en) rdata_q <= dq_in;
    end
  end
endmodule

// File: rtl/sramc_seq.sv
module sramc_seq
  import sramc_pkg::*;
#(
  parameter int RD_LEN = 4,
  parameter int WR_LEN = 5,
  parameter int HZ_LEN = 3,
  parameter int TW     = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  output logic          ready,
  output logic          accept,
  output logic          cap_en,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  input  logic          tmr_zero,
  output logic          sel_n,
  output logic          oe_n,
  output logic          we_n,
  output logic          dq_oe,
  output logic          done
);
  sramc_state_e state;

  assign ready  = (state == ST_IDLE);
  assign accept = ready && req_valid;
  assign cap_en = (state == ST_RD_CAPTURE);

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state)
      ST_RD_SETUP:   begin tmr_load = 1'b1; tmr_val = TW'(RD_LEN - 1); end
      ST_RD_CAPTURE: begin tmr_load = 1'b1; tmr_val = TW'(HZ_LEN - 1); end
      ST_WR_SETUP:   begin tmr_load = 1'b1; tmr_val = TW'(WR_LEN - 1); end
      default:       ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      sel_n <= 1'b1;
      oe_n  <= 1'b1;
      we_n  <= 1'b1;
      dq_oe <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (req_valid) begin
          sel_n <= 1'b0;
          if (req_write) begin
            dq_oe <= 1'b1;
            state <= ST_WR_SETUP;
          end else begin
            state <= ST_RD_SETUP;
          end
        end
        ST_RD_SETUP: begin
          oe_n  <= 1'b0;
          state <= ST_RD_WAIT;
        end
        ST_RD_WAIT: if (tmr_zero) state <= ST_RD_CAPTURE;
        ST_RD_CAPTURE: begin
          sel_n <= 1'b1;
          oe_n  <= 1'b1;
          done  <= 1'b1;
          state <= ST_TURNAROUND;
        end
        ST_TURNAROUND: if (tmr_zero) state <= ST_IDLE;
        ST_WR_SETUP: begin
          we_n  <= 1'b0;
          state <= ST_WR_PULSE;
        end
        ST_WR_PULSE: if (tmr_zero) begin
          we_n  <= 1'b1;
          state <= ST_WR_END;
        end
        ST_WR_END: begin
          sel_n <= 1'b1;
          dq_oe <= 1'b0;
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4: completion is a single-cycle pulse
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R2: a taken request starts an access and drops ready
  a_r2_accept_selects: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!sel_n && !ready));
endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
  import sramc_pkg::*;
#(
  parameter int CLK_NS     = 10,
  parameter bit FAST_GRADE = 1'b1,
  parameter int AW         = 18,
  parameter int DW         = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] sram_addr,
  output logic [DW-1:0] sram_dq_out,
  output logic          sram_dq_oe,
  input  logic [DW-1:0] sram_dq_in,
  output logic          sram_sel_n,
  output logic          sram_oe_n,
  output logic          sram_we_n
);
  localparam int T_RC = FAST_GRADE ? 55 : 70;
  localparam int T_OE = 35;
  localparam int T_WP = FAST_GRADE ? 45 : 55;
  localparam int T_AW = FAST_GRADE ? 45 : 60;
  localparam int T_DW = 40;
  localparam int T_HZ = FAST_GRADE ? 25 : 30;

  localparam int RD_LEN = rd_wait_len(ns2cyc(T_RC, CLK_NS), ns2cyc(T_OE, CLK_NS));
  localparam int WR_LEN = wr_pulse_len(ns2cyc(T_WP, CLK_NS), ns2cyc(T_AW, CLK_NS),
                                       ns2cyc(T_DW, CLK_NS));
  localparam int HZ_LEN = ns2cyc(T_HZ, CLK_NS);
  localparam int TW     = $clog2(imax(imax(RD_LEN, WR_LEN), HZ_LEN) + 1);
  localparam int MW     = TW + 1;

  logic          accept, cap_en, tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;

  sramc_seq #(.RD_LEN(RD_LEN), .WR_LEN(WR_LEN), .HZ_LEN(HZ_LEN), .TW(TW)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .ready(req_ready), .accept(accept), .cap_en(cap_en),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .tmr_zero(tmr_zero),
    .sel_n(sram_sel_n), .oe_n(sram_oe_n), .we_n(sram_we_n),
    .dq_oe(sram_dq_oe), .done(rsp_done)
  );

  sramc_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  sramc_dpath #(.AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rst_n(rst_n), .accept(accept), .req_addr(req_addr),
    .req_wdata(req_wdata), .cap_en(cap_en), .dq_in(sram_dq_in),
    .addr_q(sram_addr), .wdata_q(sram_dq_out), .rdata_q(rsp_rdata)
  );

  // observation counters for the timing assertions
  logic [MW-1:0] we_low_run;  // cycles write-enable has been low
  logic [MW-1:0] oe_quiet;    // cycles since output-enable last high-going, saturating

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_low_run <= '0;
      oe_quiet   <= MW'(HZ_LEN);
    end else begin
      we_low_run <= sram_we_n ? '0 : ((we_low_run == '1) ? we_low_run : we_low_run + 1'b1);
      if (!sram_oe_n)                 oe_quiet <= '0;
      else if (oe_quiet != MW'(HZ_LEN)) oe_quiet <= oe_quiet + 1'b1;
    end
  end

  // R6: write-enable pulse never shorter than the rounded minimum
  a_r6_we_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (we_low_run >= MW'(WR_LEN)));
  // R5: no drive toward memory inside the float window after a read
  a_r5_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> (oe_quiet >= MW'(HZ_LEN)));
  // R8: output enable excluded during writes and while driving
  a_r8_oe_vs_we: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (sram_oe_n && sram_dq_oe));
  a_r8_oe_vs_drive: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> sram_oe_n);
  // R7: address and write byte frozen while selected
  a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_sel_n && $past(!sram_sel_n)) |-> $stable(sram_addr));
  a_r7_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_dq_oe && $past(sram_dq_oe)) |-> $stable(sram_dq_out));
endmodule

// File: tb/tb_async_sram_ctrl.sv
module tb_async_sram_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;

  // fast instance
  logic req_valid = 0, req_write = 0;
  logic [17:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_done, sram_dq_oe, sram_sel_n, sram_oe_n, sram_we_n;
  logic [7:0]  rsp_rdata, sram_dq_out, sram_dq_in;
  logic [17:0] sram_addr;

  async_sram_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .sram_addr(sram_addr),
    .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in),
    .sram_sel_n(sram_sel_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n));

  // slow-grade instance with a fixed data source
  logic s_valid = 0, s_write = 0;
  logic s_ready, s_done, s_dq_oe, s_sel_n, s_oe_n, s_we_n;
  logic [7:0]  s_rdata, s_dq_out;
  logic [17:0] s_addr;

  async_sram_ctrl #(.FAST_GRADE(1'b0)) dut_slow (
    .clk(clk), .rst_n(rst_n), .req_valid(s_valid), .req_write(s_write),
    .req_addr(18'h2AAAA), .req_wdata(8'h77), .req_ready(s_ready),
    .rsp_done(s_done), .rsp_rdata(s_rdata), .sram_addr(s_addr),
    .sram_dq_out(s_dq_out), .sram_dq_oe(s_dq_oe), .sram_dq_in(8'h3C),
    .sram_sel_n(s_sel_n), .sram_oe_n(s_oe_n), .sram_we_n(s_we_n));

  // ---- expected timing, from the requirement formulas ----
  function automatic int b_cyc(input int ns);
    int c;
    c = ns / 10;
    if (ns % 10 != 0) c++;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int b_max3(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction
  function automatic int exp_rd_lat(input bit fast);
    return b_max3(b_cyc(fast ? 55 : 70) - 2, b_cyc(35) - 1, 1) + 2;
  endfunction
  function automatic int exp_wr_lat(input bit fast);
    int wp, aw;
    wp = b_cyc(fast ? 45 : 55);
    aw = b_cyc(fast ? 45 : 60);
    return b_max3(wp, aw - 1, b_max3(b_cyc(40) - 1, 1, 1)) + 2;
  endfunction
  function automatic logic [7:0] dflt(input logic [17:0] a);
    return a[7:0] ^ a[17:10] ^ 8'h96;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---- cycle-level memory model, updated at the falling edge ----
  logic [7:0] mem_model [logic [17:0]];
  logic [7:0] sb        [logic [17:0]];
  logic [17:0] m_prev_addr = '0;
  logic m_prev_oe_n = 1, m_prev_we_n = 1;
  logic [7:0] m_prev_dq = '0;
  int addr_run = 0, oe_run = 0, hz_left = 0, we_run = 0, dq_run = 0;
  bit drive = 0, contention = 0;

  function automatic logic [7:0] mem_rd(input logic [17:0] a);
    return mem_model.exists(a) ? mem_model[a] : dflt(a);
  endfunction

  always @(negedge clk) begin
    if (sram_sel_n || sram_addr != m_prev_addr) addr_run = 0; else addr_run++;
    if (sram_oe_n || m_prev_oe_n) oe_run = 0; else oe_run++;
    if (!sram_dq_oe || sram_dq_out != m_prev_dq) dq_run = 0; else dq_run++;
    if (!sram_sel_n && !sram_oe_n && sram_we_n) begin
      drive = 1; hz_left = b_cyc(25);
    end else if (hz_left > 0) begin
      drive = 1; hz_left--;
    end else drive = 0;
    if (drive && sram_dq_oe) contention = 1;
    if (!m_prev_we_n && sram_we_n && !sram_sel_n) begin
      chk(we_run >= b_cyc(45), "R6", "write-enable low cycles", we_run, b_cyc(45));
      chk(dq_run >= b_cyc(40), "R6", "data setup cycles", dq_run, b_cyc(40));
      chk(addr_run >= b_cyc(45), "R7", "address before end of write", addr_run, b_cyc(45));
      mem_model[sram_addr] = sram_dq_out;
    end
    we_run = sram_we_n ? 0 : we_run + 1;
    if (drive)
      sram_dq_in = (((addr_run + 1) * 10 >= 55) && ((oe_run + 1) * 10 >= 35))
                   ? mem_rd(sram_addr) : ~mem_rd(sram_addr);
    else
      sram_dq_in = 8'h00;
    m_prev_addr = sram_addr;
    m_prev_oe_n = sram_oe_n;
    m_prev_we_n = sram_we_n;
    m_prev_dq   = sram_dq_out;
  end

  // one access on the fast instance; starts and ends at a falling edge
  task automatic op(input bit wr, input logic [17:0] a, input logic [7:0] d,
                    output logic [7:0] q, output int lat, output int gap);
    int k;
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    contention = 0;
    @(negedge clk);
    req_valid = 0;
    k = 1;
    while (!rsp_done && k < 100) begin @(negedge clk); k++; end
    lat = k - 1;
    q = rsp_rdata;
    gap = 0;
    while (!req_ready && gap < 100) begin @(negedge clk); gap++; end
    if (wr) sb[a] = d;
  endtask

  function automatic logic [7:0] sb_rd(input logic [17:0] a);
    return sb.exists(a) ? sb[a] : dflt(a);
  endfunction

  initial begin : watchdog
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic [7:0] q, last_rd;
    int lat, gap, k;
    logic [17:0] pool [16];
    void'($urandom(32'h5EED1234));

    repeat (3) @(negedge clk);
    // R1: state while in reset
    chk(sram_sel_n && sram_oe_n && sram_we_n && !sram_dq_oe && req_ready && !rsp_done,
        "R1", "strobes during reset", {sram_sel_n, sram_oe_n, sram_we_n, sram_dq_oe}, 4'he);
    rst_n = 1;
    @(negedge clk);
    chk(sram_sel_n && sram_oe_n && sram_we_n && !sram_dq_oe && req_ready && !rsp_done,
        "R1", "strobes after reset", {req_ready, rsp_done}, 2'b10);
    chk(s_sel_n && s_oe_n && s_we_n && !s_dq_oe && s_ready, "R1", "slow instance idle",
        {s_sel_n, s_oe_n, s_we_n, s_dq_oe}, 4'he);

    // R6/R4: write latency and release
    op(1, 18'h00000, 8'h00, q, lat, gap);
    chk(lat == exp_wr_lat(1), "R6", "write latency", lat, exp_wr_lat(1));
    chk(gap == 0, "R4", "ready with write done", gap, 0);
    op(1, 18'h3FFFF, 8'hFF, q, lat, gap);
    // R3/R5: read latency, data and turnaround
    op(0, 18'h3FFFF, 8'h00, q, lat, gap);
    chk(lat == exp_rd_lat(1), "R3", "read latency", lat, exp_rd_lat(1));
    chk(q == 8'hFF, "R3", "read top address", q, 8'hFF);
    chk(gap == b_cyc(25), "R5", "turnaround cycles", gap, b_cyc(25));
    op(0, 18'h00000, 8'h00, q, lat, gap);
    chk(q == 8'h00, "R7", "read address zero", q, 8'h00);
    op(0, 18'h01234, 8'h00, q, lat, gap);
    chk(q == dflt(18'h01234), "R3", "read unwritten", q, dflt(18'h01234));
    last_rd = q;

    // R5: write right after a read — memory still floating
    op(1, 18'h01234, 8'hA5, q, lat, gap);
    chk(!contention, "R5", "bus contention after read", contention, 0);
    chk(rsp_rdata == last_rd, "R4", "read byte kept over write", rsp_rdata, last_rd);
    op(0, 18'h01234, 8'h00, q, lat, gap);
    chk(q == 8'hA5, "R7", "read after write", q, 8'hA5);

    // R2: request while busy is ignored
    op(1, 18'h00123, 8'h11, q, lat, gap);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 18'h00777;
    @(negedge clk);
    chk(!req_ready && !sram_sel_n, "R2", "taken request drops ready", req_ready, 0);
    req_write = 1; req_addr = 18'h00123; req_wdata = 8'hEE;
    @(negedge clk);
    req_valid = 0;
    k = 0;
    while (!rsp_done && k < 100) begin @(negedge clk); k++; end
    op(0, 18'h00123, 8'h00, q, lat, gap);
    chk(q == 8'h11, "R2", "busy request had no effect", q, 8'h11);

    // random mix against the scoreboard
    foreach (pool[i]) pool[i] = 18'($urandom);
    for (int n = 0; n < 250; n++) begin
      logic [17:0] a;
      bit wr;
      wr = $urandom_range(1, 0) == 1;
      a = ($urandom_range(3, 0) != 0) ? pool[$urandom_range(15, 0)] : 18'($urandom);
      if (wr) begin
        op(1, a, 8'($urandom), q, lat, gap);
        chk(!contention, "R5", "random write contention", contention, 0);
        chk(lat == exp_wr_lat(1), "R6", "random write latency", lat, exp_wr_lat(1));
      end else begin
        op(0, a, 8'h00, q, lat, gap);
        chk(q == sb_rd(a), "R7", "random read data", q, sb_rd(a));
        chk(lat == exp_rd_lat(1), "R3", "random read latency", lat, exp_rd_lat(1));
      end
    end

    // slow grade: latencies from the slow figures
    s_valid = 1; s_write = 0;
    @(negedge clk);
    s_valid = 0;
    k = 1;
    while (!s_done && k < 100) begin @(negedge clk); k++; end
    chk(k - 1 == exp_rd_lat(0), "R3", "slow read latency", k - 1, exp_rd_lat(0));
    chk(s_rdata == 8'h3C, "R3", "slow read data", s_rdata, 8'h3C);
    @(negedge clk);
    chk(!s_done, "R4", "slow done single cycle", s_done, 0);
    while (!s_ready) @(negedge clk);
    s_valid = 1; s_write = 1;
    @(negedge clk);
    s_valid = 0;
    k = 1;
    while (!s_done && k < 100) begin @(negedge clk); k++; end
    chk(k - 1 == exp_wr_lat(0), "R6", "slow write latency", k - 1, exp_wr_lat(0));

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule